// File: doc/BRIEF.md
# Serial Port Register Block with FIFO-Level Interrupts

This block is the register side of a byte-oriented serial port. Software reaches it through a small word-addressed register port. Each byte it writes is queued in an 8-deep transmit FIFO. Bytes arriving from the line receiver are queued in an 8-deep receive FIFO, and software pops them by reading. Status is carried in bit 31 of the two data registers, so there is no separate status register: the transmit data register shows that the FIFO is full, and the receive data register shows that it is empty.

Interrupts do not report individual events. They compare FIFO levels against programmable thresholds, and each source stays pending for as long as its level condition holds. The transmit source asks for more data while the transmit FIFO holds fewer bytes than its threshold. The receive source asks to be drained while the receive FIFO holds more bytes than its threshold. A single interrupt line is the OR of the pending sources that are enabled.

The bit-level shifters sit outside this block. Bytes leave it on a valid/ready stream. `txs_valid` stays high while transmit is enabled and the transmit FIFO is not empty, and `txs_data` is held until `txs_ready` is seen. Bytes enter it on a second valid/ready stream. `rxs_ready` is high only while receive is enabled and the receive FIFO has room, so a full FIFO or a disabled receiver holds the sender back; nothing is lost. The block also drives the divisor, stop-bit and enable settings out to the shifters. One bit lasts divisor+1 clock cycles, and the frame is fixed at 8 data bits with no parity.

Top module: `sport_ctrl`

## Requirements
- R1: After reset, the transmit control, receive control, interrupt-enable, pending and divisor registers all read zero. `irq`, `txs_valid` and `rxs_ready` are low, and a read of the receive data register returns bit 31 set.
- R2: A write to offset 0x00 queues `reg_wdata[7:0]`. While transmit is enabled, the queued bytes leave on the transmit stream in write order, one per cycle in which `txs_valid` and `txs_ready` are both high. While transmit is disabled, `txs_valid` stays low.
- R3: A read of offset 0x00 returns bit 31 set exactly when 8 bytes are queued. A write while the FIFO is full is dropped, so the stream later delivers only the first 8 bytes.
- R4: A read of offset 0x04 returns the oldest received byte in bits 7:0 with bit 31 clear, and removes that byte. When the FIFO is empty the read returns bit 31 set and removes nothing.
- R5: `rxs_ready` is high exactly when receive is enabled and fewer than 8 bytes are held. A byte offered while `rxs_ready` is low is not taken.
- R6: Offset 0x08 holds transmit enable (bit 0), two-stop-bit select (bit 1) and the transmit threshold (bits 18:16). Offset 0x0C holds receive enable (bit 0) and the receive threshold (bits 18:16). Both read back exactly as written, with other bits zero, and drive `tx_on`, `two_stop` and `rx_on`.
- R7: Offset 0x18 holds a 16-bit divisor. It reads back in bits 15:0, with upper bits zero, and drives `baud_div`.
- R8: Bit 0 of the pending register (offset 0x14) is set exactly when the transmit FIFO level is below the transmit threshold.
- R9: Bit 1 of the pending register is set exactly when the receive FIFO level is above the receive threshold.
- R10: Offset 0x10 holds enable bits in the same layout as the pending register (bit 0 transmit, bit 1 receive). `irq` equals the OR over both bits of enable AND pending.
- R11: Writes to the pending register have no effect; it always reflects the FIFO levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Byte offset of the register; bits 1:0 must be zero |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe; pops the receive FIFO at offset 0x04 |
| reg_rdata | output | 32 | Contents of the addressed register, available in the same cycle |
| irq | output | 1 | Level interrupt |
| txs_valid | output | 1 | Transmit byte available |
| txs_ready | input | 1 | Transmitter takes the byte |
| txs_data | output | 8 | Transmit byte |
| rxs_valid | input | 1 | Received byte offered |
| rxs_ready | output | 1 | Block accepts the byte |
| rxs_data | input | 8 | Received byte |
| baud_div | output | 16 | Bit period minus one, in clock cycles |
| two_stop | output | 1 | Transmitter sends two stop bits |
| tx_on | output | 1 | Transmit enable |
| rx_on | output | 1 | Receive enable |

## Verification
A wrong FIFO pointer or level shows up at the data ports as a reordered, repeated or missing byte. It appears on the first transmit handshake or receive-data read after the fault. The same fault shows as a pending bit that disagrees with the level the bench has tracked, and the next pending-register read or `irq` sample reveals it in that same cycle. A corrupted control field shows on the next readback and on the configuration pins with no delay. A flag bit computed from the wrong boundary, such as full at 7 or empty with one byte left, shows when the ninth write is dropped or when the extra read returns data.

// File: rtl/sport_pkg.sv
`timescale 1ns/1ps
package sport_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned FLAG_B  = 31;
  localparam int unsigned MARK_LSB = 16;

  typedef enum logic [2:0] {
    SEL_TXD = 3'd0,
    SEL_RXD = 3'd1,
    SEL_TXC = 3'd2,
    SEL_RXC = 3'd3,
    SEL_IE  = 3'd4,
    SEL_IP  = 3'd5,
    SEL_DIV = 3'd6,
    SEL_NONE = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/sport_fifo.sv
`timescale 1ns/1ps
module sport_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [LW-1:0] cnt;
  logic do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt == LW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rd_ptr];
  assign level_o = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LW'(DEPTH)); // R3
  AST_LEVEL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_o) |=> (cnt == $past(cnt) + 1'b1)); // R2
  AST_LEVEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i) |=> $stable(cnt)); // R4
endmodule

// File: rtl/sport_wm.sv
`timescale 1ns/1ps
module sport_wm #(
  parameter int unsigned LW    = 4,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LW-1:0]    tx_level,
  input  logic [LW-1:0]    rx_level,
  input  logic [CNT_W-1:0] tx_mark,
  input  logic [CNT_W-1:0] rx_mark,
  input  logic [1:0]       ie,
  output logic [1:0]       ip,
  output logic             irq
);
  assign ip[0] = (tx_level < LW'(tx_mark));
  assign ip[1] = (rx_level > LW'(rx_mark));
  assign irq   = |(ie & ip);

  AST_TX_EMPTY_ASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0 && tx_mark != '0) |-> ip[0]); // R8
  AST_RX_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> !ip[1]); // R9
endmodule

// File: rtl/sport_ctrl.sv
`timescale 1ns/1ps
module sport_ctrl
  import sport_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned CNT_W  = 3,
  localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_rd,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              txs_valid,
  input  logic              txs_ready,
  output logic [DATA_W-1:0] txs_data,
  input  logic              rxs_valid,
  output logic              rxs_ready,
  input  logic [DATA_W-1:0] rxs_data,
  output logic [DIV_W-1:0]  baud_div,
  output logic              two_stop,
  output logic              tx_on,
  output logic              rx_on
);
  reg_sel_e         sel;
  logic [CNT_W-1:0] tx_mark, rx_mark;
  logic [1:0]       ie, ip;
  logic [LW-1:0]    tx_level, rx_level;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [DATA_W-1:0] rx_head;
  wire              unused_wbits = ^reg_wdata[REG_W-1:MARK_LSB+CNT_W];

  assign sel = (reg_addr[1:0] == 2'b00) ? reg_sel_e'(reg_addr[4:2]) : SEL_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_on    <= 1'b0;
      two_stop <= 1'b0;
      rx_on    <= 1'b0;
      tx_mark  <= '0;
      rx_mark  <= '0;
      ie       <= '0;
      baud_div <= '0;
    end else if (reg_wr) begin
      case (sel)
        SEL_TXC: begin
          tx_on    <= reg_wdata[0];
          two_stop <= reg_wdata[1];
          tx_mark  <= reg_wdata[MARK_LSB +: CNT_W];
        end
        SEL_RXC: begin
          rx_on   <= reg_wdata[0];
          rx_mark <= reg_wdata[MARK_LSB +: CNT_W];
        end
        SEL_IE:  ie       <= reg_wdata[1:0];
        SEL_DIV: baud_div <= reg_wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  sport_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk, .rst_n,
    .push_i  (reg_wr && sel == SEL_TXD),
    .data_i  (reg_wdata[DATA_W-1:0]),
    .pop_i   (txs_valid && txs_ready),
    .data_o  (txs_data),
    .level_o (tx_level),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  sport_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk, .rst_n,
    .push_i  (rxs_valid && rxs_ready),
    .data_i  (rxs_data),
    .pop_i   (reg_rd && sel == SEL_RXD),
    .data_o  (rx_head),
    .level_o (rx_level),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  assign txs_valid = tx_on && !tx_empty;
  assign rxs_ready = rx_on && !rx_full;

  sport_wm #(.LW(LW), .CNT_W(CNT_W)) u_wm (
    .clk, .rst_n,
    .tx_level, .rx_level, .tx_mark, .rx_mark, .ie, .ip, .irq
  );

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_TXD: reg_rdata[FLAG_B] = tx_full;
      SEL_RXD: begin
        reg_rdata[FLAG_B] = rx_empty;
        if (!rx_empty) reg_rdata[DATA_W-1:0] = rx_head;
      end
      SEL_TXC: begin
        reg_rdata[0] = tx_on;
        reg_rdata[1] = two_stop;
        reg_rdata[MARK_LSB +: CNT_W] = tx_mark;
      end
      SEL_RXC: begin
        reg_rdata[0] = rx_on;
        reg_rdata[MARK_LSB +: CNT_W] = rx_mark;
      end
      SEL_IE:  reg_rdata[1:0] = ie;
      SEL_IP:  reg_rdata[1:0] = ip;
      SEL_DIV: reg_rdata[DIV_W-1:0] = baud_div;
      default: ;
    endcase
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (txs_valid && !txs_ready && !(reg_wr && sel == SEL_TXC))
      |=> (txs_valid && $stable(txs_data))); // R2
  AST_RX_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == LW'(DEPTH)) |-> !rxs_ready); // R5
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie != 2'b00)); // R10
endmodule

// File: tb/sport_ctrl_test.sv
`timescale 1ns/1ps
module sport_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, txs_valid, rxs_ready, two_stop, tx_on, rx_on;
  logic        txs_ready = 1'b0, rxs_valid = 1'b0;
  logic [7:0]  txs_data, rxs_data = '0;
  logic [15:0] baud_div;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  localparam logic [4:0] A_TXD = 5'h00, A_RXD = 5'h04, A_TXC = 5'h08,
                         A_RXC = 5'h0C, A_IE = 5'h10, A_IP = 5'h14, A_DIV = 5'h18;

  always #2 clk = ~clk;

  sport_ctrl uut (
    .clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata, .reg_rd, .reg_rdata, .irq,
    .txs_valid, .txs_ready, .txs_data, .rxs_valid, .rxs_ready, .rxs_data,
    .baud_div, .two_stop, .tx_on, .rx_on
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic rx_offer(input logic [7:0] b, output logic took);
    @(negedge clk);
    rxs_valid = 1'b1; rxs_data = b;
    #1 took = rxs_ready;
    @(posedge clk); #1 rxs_valid = 1'b0;
  endtask

  function automatic logic [31:0] exp_ip(input int txl, input int txc, input int rxl, input int rxc);
    return {30'b0, (rxl > rxc), (txl < txc)};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    logic [7:0]  q [16];
    logic        took;
    int          got, txc, rxc;
    void'($urandom(32'h5EED_0C47));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(A_TXC, d); chk("R1 txctrl", d, 0);
    rd(A_RXC, d); chk("R1 rxctrl", d, 0);
    rd(A_IE, d);  chk("R1 ie", d, 0);
    rd(A_IP, d);  chk("R1 ip", d, 0);
    rd(A_DIV, d); chk("R1 div", d, 0);
    rd(A_RXD, d); chk("R1 rx empty flag", d, 32'h8000_0000);
    chk("R1 pins", {irq, txs_valid, rxs_ready}, 0);

    // R7 divisor
    for (int i = 0; i < 3; i++) begin
      logic [31:0] v = $urandom;
      wr(A_DIV, v);
      rd(A_DIV, d); chk("R7 readback", d, {16'b0, v[15:0]});
      chk("R7 pin", {16'b0, baud_div}, {16'b0, v[15:0]});
    end

    // R6 control fields
    for (int i = 0; i < 3; i++) begin
      logic [31:0] v = $urandom & 32'hFFF8_FFFC;
      wr(A_TXC, v);
      rd(A_TXC, d); chk("R6 txctrl", d, v & 32'h0007_0003);
      chk("R6 tx pins", {30'b0, two_stop, tx_on}, {30'b0, v[1], v[0]});
      wr(A_RXC, v ^ 32'h0003_0002);
      rd(A_RXC, d); chk("R6 rxctrl", d, (v ^ 32'h0003_0002) & 32'h0007_0001);
      chk("R6 rx pin", {31'b0, rx_on}, {31'b0, v[0]});
    end
    wr(A_TXC, 0); wr(A_RXC, 0);

    // R2/R3 fill transmit FIFO with transmit disabled, ninth write dropped
    for (int i = 0; i < 9; i++) begin
      q[i] = 8'($urandom);
      wr(A_TXD, {24'hABCDEF, q[i]});
      rd(A_TXD, d);
      chk("R3 full flag", d, (i >= 7) ? 32'h8000_0000 : 32'h0);
    end
    chk("R2 valid low while disabled", {31'b0, txs_valid}, 0);
    txs_ready = 1'b1;
    wr(A_TXC, 32'h1);
    got = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (txs_valid) begin
        if (got < 9) chk("R2 byte order", {24'b0, txs_data}, {24'b0, q[got]});
        got++;
      end
    end
    chk("R3 ninth byte dropped", got, 8);
    txs_ready = 1'b0;
    wr(A_TXC, 0);

    // R8/R10 transmit threshold, random levels
    wr(A_IE, 32'h1);
    for (int it = 0; it < 8; it++) begin
      int k = (it == 0) ? 0 : ((it == 1) ? 8 : int'($urandom_range(0, 8)));
      txc = (it == 0) ? 1 : int'($urandom_range(0, 7));
      wr(A_TXC, txc << 16);
      for (int i = 0; i < k; i++) wr(A_TXD, $urandom);
      rd(A_IP, d); chk("R8 tx pending", d, exp_ip(k, txc, 0, 0));
      chk("R10 irq tx", {31'b0, irq}, {31'b0, (k < txc)});
      txs_ready = 1'b1;
      wr(A_TXC, (txc << 16) | 1);
      repeat (10) @(posedge clk);
      #1 txs_ready = 1'b0;
      wr(A_TXC, txc << 16);
    end
    wr(A_TXC, 32'h1_0000);
    txc = 1;
    // R10 enable masks the pending transmit source; R11 pending is not writable
    wr(A_IE, 0);
    chk("R10 irq masked", {31'b0, irq}, 0);
    wr(A_IP, 32'hFFFF_FFFF);
    rd(A_IP, d); chk("R11 ip unchanged", d, exp_ip(0, 1, 0, 0));
    wr(A_IE, 32'h1);
    chk("R10 irq enabled", {31'b0, irq}, 1);
    wr(A_IE, 32'h2);

    // R5 receive disabled refuses bytes
    rx_offer(8'h5A, took);
    chk("R5 ready low when disabled", {31'b0, took}, 0);
    rd(A_RXD, d); chk("R5 nothing taken", d, 32'h8000_0000);

    // R4/R5/R9 receive path, random thresholds and counts
    for (int it = 0; it < 6; it++) begin
      int n = (it == 0) ? 9 : int'($urandom_range(1, 9));
      int held = (n > 8) ? 8 : n;
      rxc = (it == 0) ? 0 : int'($urandom_range(0, 7));
      wr(A_RXC, (rxc << 16) | 1);
      for (int i = 0; i < n; i++) begin
        q[i] = 8'($urandom);
        rx_offer(q[i], took);
        chk("R5 ready vs fill", {31'b0, took}, {31'b0, (i < 8)});
      end
      rd(A_IP, d); chk("R9 rx pending", d, exp_ip(0, txc, held, rxc));
      chk("R10 irq rx", {31'b0, irq}, {31'b0, (held > rxc)});
      for (int i = 0; i < held; i++) begin
        rd(A_RXD, d); chk("R4 oldest byte", d, {24'b0, q[i]});
      end
      rd(A_RXD, d); chk("R4 empty flag", d, 32'h8000_0000);
      rd(A_IP, d); chk("R9 drained", d, exp_ip(0, txc, 0, rxc));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule